// File: doc/BRIEF.md
# Lane-Split Saturating Add/Subtract Unit

This block adds or subtracts two 32-bit words that hold packed unsigned elements. A two-bit lane mode sets how the word is divided. It can be four independent byte lanes, two independent halfword lanes, or one full-width lane. Internally the word is built from four byte slices. The carry between two slices is cut wherever the mode puts a lane edge, and it passes through wherever the mode joins the slices. One datapath therefore serves all three element widths.

When saturation is enabled, each lane that goes out of range is clamped on its own. An add that overflows gives the lane's all-ones value, and a subtract that borrows gives zero. Lanes that stay in range are not affected. When saturation is disabled, every lane wraps modulo its own width. A four-bit flag vector marks the lanes that went out of range. With the default parameters the result passes through one output register, which carries a valid bit.

Top module: `psimd_add`

## Requirements
- R1: Lane mode 2'b00 treats the word as four 8-bit lanes (bits 7:0, 15:8, 23:16, 31:24), and no carry or borrow crosses from one byte lane into the next.
- R2: Lane mode 2'b01 treats the word as two 16-bit lanes (bits 15:0 and 31:16). The carry passes between bytes inside a lane, but it does not pass from bit 15 into bit 16.
- R3: Lane mode 2'b10 computes one 32-bit result. The reserved code 2'b11 behaves exactly like 2'b10.
- R4: An add (sub=0) with sat_en=1 returns the all-ones value of the lane width in any lane whose unsigned sum exceeds that width. For example, in 16-bit mode 0xEA2C plus 0xD12A gives 0xFFFF.
- R5: With sat_en=0, each lane returns its sum or difference modulo 2 to the power of its width, and the carry-out or borrow is discarded.
- R6: With sub=1, each lane computes a minus b. If a is less than b in a lane and sat_en=1, that lane returns zero.
- R7: A flag bit ovf[k] goes high for an add carry-out or a subtract borrow of a lane. It is raised only on the top byte slice of that lane: bit k for byte lanes, bits 1 and 3 for halfword lanes, bit 3 for the full word. The flag does not depend on sat_en, and all other flag bits are zero.
- R8: result, ovf and out_valid appear one clock after the inputs are presented, and out_valid equals the in_valid of the previous cycle. Reset forces out_valid, result and ovf to zero.
- R9: While in_valid is low, result and ovf keep their last captured values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The operands in this cycle are to be captured |
| mode | input | 2 | Lane partitioning: 00 four bytes, 01 two halfwords, 1x one word |
| sub | input | 1 | 0 adds, 1 subtracts b from a |
| sat_en | input | 1 | Clamp out-of-range lanes instead of wrapping |
| a | input | 32 | First packed operand |
| b | input | 32 | Second packed operand |
| out_valid | output | 1 | result and ovf hold a fresh value |
| result | output | 32 | Packed lane results |
| ovf | output | 4 | Per-slice carry/borrow flags, set only on the top slice of each lane |

## Verification
A wrongly gated slice carry shows up in the next valid result as a neighbouring lane that is off by exactly one in its lowest bit. A wrong clamp shows up as a lane that wraps instead of pinning, or as an in-range lane that gets pinned. Both appear one cycle after the operands go in. Corner operands at 0, the lane maximum and the maximum minus one stress every lane edge in every mode. A broken capture enable or valid register shows in the very next idle cycle, as a changed result or as out_valid out of step with in_valid.

// File: rtl/psimd_add.sv
module psimd_add #(
  parameter int SLICE_W = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             mode,
  input  logic                   sub,
  input  logic                   sat_en,
  input  logic [4*SLICE_W-1:0]   a,
  input  logic [4*SLICE_W-1:0]   b,
  output logic                   out_valid,
  output logic [4*SLICE_W-1:0]   result,
  output logic [3:0]             ovf
);
  localparam int NS = 4;
  localparam int DW = NS * SLICE_W;

  logic          bytes_mode, half_mode;
  logic [NS:1]   cy;
  logic [NS-1:0] cin, top, ovf_c;
  logic [DW-1:0] sum_c, res_c;

  assign bytes_mode = (mode == 2'b00);
  assign half_mode  = (mode == 2'b01);

  for (genvar i = 0; i < NS; i++) begin : g_slice
    logic [SLICE_W-1:0] bx;
    logic               clamp;
    if (i == 0) begin : g_lsb
      assign cin[i] = sub;
    end else if (i == 2) begin : g_mid
      assign cin[i] = (bytes_mode || half_mode) ? sub : cy[i];
    end else begin : g_odd
      assign cin[i] = bytes_mode ? sub : cy[i];
    end
    assign bx = b[i*SLICE_W +: SLICE_W] ^ {SLICE_W{sub}};
    assign {cy[i+1], sum_c[i*SLICE_W +: SLICE_W]} =
      {1'b0, a[i*SLICE_W +: SLICE_W]} + {1'b0, bx} + {{SLICE_W{1'b0}}, cin[i]};
    if (i == NS-1) begin : g_top
      assign top[i] = 1'b1;
    end else if (i == 1) begin : g_half_top
      assign top[i] = bytes_mode || half_mode;
    end else begin : g_byte_top
      assign top[i] = bytes_mode;
    end
    assign ovf_c[i] = top[i] & (cy[i+1] ^ sub);
    assign clamp = sat_en & (bytes_mode ? ovf_c[i] :
                             half_mode  ? ovf_c[i | 1] : ovf_c[NS-1]);
    assign res_c[i*SLICE_W +: SLICE_W] =
      clamp ? {SLICE_W{~sub}} : sum_c[i*SLICE_W +: SLICE_W];
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        result    <= '0;
        ovf       <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          result <= res_c;
          ovf    <= ovf_c;
        end
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = res_c;
    assign ovf       = ovf_c;
  end
endmodule

// File: rtl/psimd_add_chk.sv
module psimd_add_chk #(
  parameter int SLICE_W = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [1:0]           mode,
  input logic                 sub,
  input logic                 sat_en,
  input logic                 out_valid,
  input logic [4*SLICE_W-1:0] result,
  input logic [3:0]           ovf
);
  if (REG_OUT) begin : g_chk
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
    end

    always @(posedge clk) begin
      if (!rst_n) assert_reset_clear_R8: assert (!out_valid && ovf == 4'b0);
    end

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> out_valid == $past(in_valid));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !$past(in_valid) |-> $stable(result) && $stable(ovf));

    assert_half_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seen && out_valid && $past(mode) == 2'b01 |-> !ovf[0] && !ovf[2]);

    assert_word_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seen && out_valid && $past(mode[1]) |-> ovf[2:0] == 3'b000);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      seen && out_valid && $past(sat_en && !sub && mode[1]) && ovf[3] |-> &result);

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seen && out_valid && $past(sat_en && sub && mode[1]) && ovf[3] |-> result == '0);
  end
endmodule

bind psimd_add psimd_add_chk #(.SLICE_W(SLICE_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .sub(sub),
  .sat_en(sat_en), .out_valid(out_valid), .result(result), .ovf(ovf)
);

// File: tb/psimd_add_tb.sv
`timescale 1ns/1ps
module psimd_add_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sub = 1'b0;
  logic        sat_en = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  ovf;

  int checks = 0, errors = 0;
  logic        exp_v = 1'b0;
  logic [31:0] exp_r = '0;
  logic [3:0]  exp_f = '0;
  string       exp_tag = "R8";

  always #2.5 clk = ~clk;

  psimd_add u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .sub(sub), .sat_en(sat_en), .a(a), .b(b), .out_valid(out_valid),
    .result(result), .ovf(ovf));

  function automatic int lane_w(input logic [1:0] m);
    return (m == 2'b00) ? 8 : (m == 2'b01) ? 16 : 32;
  endfunction

  function automatic void ref_op(input logic [1:0] m, input logic s, input logic st,
                                 input logic [31:0] x, input logic [31:0] y,
                                 output logic [31:0] r, output logic [3:0] f);
    int lw = lane_w(m);
    longint mx = (64'd1 << lw) - 1;
    r = '0;
    f = '0;
    for (int l = 0; l < 32 / lw; l++) begin
      longint xa = (longint'(x) >> (l * lw)) & mx;
      longint ya = (longint'(y) >> (l * lw)) & mx;
      longint v;
      bit o;
      if (!s) begin
        v = xa + ya;
        o = v > mx;
        if (o) v = st ? mx : (v & mx);
      end else begin
        o = xa < ya;
        v = o ? (st ? 0 : ((xa - ya) & mx)) : (xa - ya);
      end
      r = r | (32'(v) << (l * lw));
      if (o) f[(l * lw + lw) / 8 - 1] = 1'b1;
    end
  endfunction

  function automatic logic [31:0] corner(input logic [1:0] m);
    int lw = lane_w(m);
    longint mx = (64'd1 << lw) - 1;
    logic [31:0] w = '0;
    for (int l = 0; l < 32 / lw; l++) begin
      int pick = $urandom_range(2);
      longint v = (pick == 0) ? 0 : (pick == 1) ? mx : mx - 1;
      w = w | (32'(v) << (l * lw));
    end
    return w;
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic s, input logic st);
    string mt = (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" : "R3";
    string ot = s ? "R6" : (st ? "R4" : "R5");
    return {mt, " ", ot};
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_v) begin
      errors++;
      $display("FAIL R8 out_valid actual %0b expected %0b", out_valid, exp_v);
    end
    checks++;
    if (result !== exp_r) begin
      errors++;
      $display("FAIL %s result actual %08h expected %08h", exp_tag, result, exp_r);
    end
    checks++;
    if (ovf !== exp_f) begin
      errors++;
      $display("FAIL R7 (%s) ovf actual %04b expected %04b", exp_tag, ovf, exp_f);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] m, input logic s, input logic st,
                      input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    compare();
    in_valid = v; mode = m; sub = s; sat_en = st; a = x; b = y;
    exp_v = v;
    if (v) begin
      ref_op(m, s, st, x, y, exp_r, exp_f);
      exp_tag = tag_of(m, s, st);
    end else begin
      exp_tag = "R9";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || ovf !== '0) begin
      errors++;
      $display("FAIL R8 reset state actual %0b/%08h/%04b expected 0/00000000/0000",
               out_valid, result, ovf);
    end
    rst_n = 1'b1;
    // R4 example from the requirement, upper halfword left at zero
    step(1'b1, 2'b01, 1'b0, 1'b1, 32'h0000_EA2C, 32'h0000_D12A);
    // R5 same operands wrap
    step(1'b1, 2'b01, 1'b0, 1'b0, 32'h0000_EA2C, 32'h0000_D12A);
    // R1 byte carry must not leak; R2 must leak within halfword only
    step(1'b1, 2'b00, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0101_0101);
    step(1'b1, 2'b01, 1'b0, 1'b0, 32'h00FF_00FF, 32'h0001_0001);
    // R3 reserved code acts as full word
    step(1'b1, 2'b11, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001);
    step(1'b1, 2'b11, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0001);
    // R6 borrow clamps to zero
    step(1'b1, 2'b00, 1'b1, 1'b1, 32'h0510_00FF, 32'h0620_01FE);
    // R9 idle cycles with changing inputs
    for (int k = 0; k < 4; k++)
      step(1'b0, 2'(k), 1'($urandom_range(1)), 1'b1, $urandom, $urandom);
    // corners and random over all modes and settings
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int st = 0; st < 2; st++)
          for (int n = 0; n < 40; n++) begin
            logic [31:0] x = (n < 20) ? corner(2'(m)) : $urandom;
            logic [31:0] y = (n % 3 == 0) ? $urandom : corner(2'(m));
            step(1'b1, 2'(m), 1'(s), 1'(st), x, y);
            if (n % 13 == 0) step(1'b0, 2'(m), 1'(s), 1'(st), $urandom, $urandom);
          end
    step(1'b0, 2'b00, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired before the run completed");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule